// File: doc/BRIEF.md
# BISYNC Transmit Framer

This block builds the outgoing byte stream of a binary synchronous link. An upstream source hands it buffers one byte at a time. The first byte of each buffer carries five control flags: clear the check sum, send a leading DLE, transparent mode, include in the check sum, and last buffer. A downstream serialiser pulls one byte whenever it raises `outReady`. In every such cycle the framer presents a byte on `outData`. That byte is a buffer byte, an inserted control character, a check byte, or idle fill.

In transparent mode the framer doubles every data byte equal to DLE. When data runs dry it fills with DLE-SYNC pairs, and a pair is never split. In normal mode it fills with single SYNC characters and sends data as it is. The framer keeps a CRC16 and an 8-bit XOR longitudinal check side by side. After a last buffer it appends the selected check without stuffing, and then idles on SYNC. Transparent buffers always close with CRC16.

For each finished buffer a one-cycle status report gives two results. One is whether the buffer ran dry: it was not last and no next buffer was waiting. The other is whether clear-to-send dropped while the buffer was being sent.

Top module: `bsyncTxFramer`

## Requirements
- R1: Out of reset, and until the first buffer starts, every pulled byte is `cfgSync`. No input byte is accepted and no status is reported.
- R2: In normal mode, a pull with no buffer waiting yields `cfgSync`.
- R3: In transparent mode, a pull with no buffer waiting yields `cfgDle`, and the next pull always yields `cfgSync`, even if a buffer has arrived in the meantime.
- R4: A buffer whose lead flag (`inFlagLead`) is set is preceded by one `cfgDle`. That DLE does not consume an input byte.
- R5: In a transparent buffer, a data byte equal to `cfgDle` is followed at the very next pull by an inserted `cfgDle` that consumes no input. In a normal buffer no DLE is inserted.
- R6: `inFlagRst` clears both check accumulators before the buffer's first byte. Only bytes of buffers with `inFlagIncl` set are accumulated. Inserted DLEs, fill and check bytes are never accumulated.
- R7: After a last buffer (`inFlagLast`), the check bytes are sent unstuffed. With `cfgUseLrc`=0 this is the CRC16: polynomial x^16+x^15+x^2+1, bits taken least significant first, initial value zero, low byte first. With `cfgUseLrc`=1 and a normal buffer it is one XOR byte.
- R8: A last buffer with the transparent flag set closes with the two CRC16 bytes, whatever `cfgUseLrc` says.
- R9: At the first pull after a buffer's final byte, `stValid` pulses. `stUnderrun` is high when that buffer was not last and no next buffer is waiting at that pull.
- R10: `stCtsLost` is high in a buffer's status when `ctsOk` was low in any cycle from the buffer's first pulled byte to its final one.
- R11: After the check bytes of a last buffer, idle fill is `cfgSync` and the mode is normal.
- R12: After a buffer that is not last, the idle mode follows that buffer's transparent flag.
- R13: `inReady` is high only in a pull cycle where `outData` equals `inData`. Input bytes leave the framer in order, one per pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSync | input | 8 | SYNC character value (usually 0x32) |
| cfgDle | input | 8 | DLE character value (usually 0x10) |
| cfgUseLrc | input | 1 | 1: normal buffers close with the XOR check; 0: CRC16 |
| ctsOk | input | 1 | Clear-to-send from the modem, high when asserted |
| inValid | input | 1 | An input byte is presented |
| inReady | output | 1 | The presented byte is taken this cycle |
| inData | input | 8 | Input byte |
| inStart | input | 1 | First byte of a buffer; the flags are valid with it |
| inEnd | input | 1 | Final byte of a buffer |
| inFlagRst | input | 1 | Clear the check accumulators before this buffer |
| inFlagLead | input | 1 | Send one DLE before this buffer |
| inFlagTransp | input | 1 | Buffer is transparent; sets the idle mode after it |
| inFlagIncl | input | 1 | Accumulate this buffer's bytes |
| inFlagLast | input | 1 | Last buffer of the message; append the check |
| outReady | input | 1 | Serialiser pulls a byte this cycle |
| outData | output | 8 | Byte handed to the serialiser in a pull cycle |
| stValid | output | 1 | Status report for the previous buffer |
| stUnderrun | output | 1 | That buffer ran dry |
| stCtsLost | output | 1 | Clear-to-send dropped during that buffer |

## Verification
Some rules are checked in every cycle. Input bytes are only taken in a pull cycle and pass through unchanged. A consumed DLE in a transparent buffer is followed by an inserted DLE that takes no input. Status flags never appear without `stValid`, and `stValid` never appears without a pull.

Other behaviour needs the bench's scenarios. These cover the exact check values, the reset and include gating across buffers, and the forced CRC in transparent mode. They also cover unbroken DLE-SYNC fill, the choice of fill after last and non-last buffers, and the underrun and clear-to-send results for back-to-back and starved buffers. The bench shows these by comparing against its reference model, under both continuous and sparse pulling.

// File: rtl/bsyncTxPkg.sv
package bsyncTxPkg;

  // Byte source selected by the sequencer for the current pull
  typedef enum logic [2:0] {
    SEL_SYNC,
    SEL_DLE,
    SEL_DATA,
    SEL_CRCLO,
    SEL_CRCHI,
    SEL_LRC
  } byteSelE;

  // Strobes from control to datapath
  typedef struct packed {
    byteSelE sel;
    logic    accClr;
    logic    accEn;
  } dpCtlT;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_SYNC2,
    ST_DATA,
    ST_STUFF,
    ST_CHK0,
    ST_CHK1
  } txStateE;

endpackage

// File: rtl/bsyncTxDatapath.sv
module bsyncTxDatapath
  import bsyncTxPkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'hA001
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] cfgSync,
  input  logic [DATA_W-1:0] cfgDle,
  output logic [DATA_W-1:0] outData,
  output logic              dataIsDle
);

  localparam int HI_LSB = CRC_W - DATA_W;

  logic [CRC_W-1:0]  crcQ, crcBase, crcStep;
  logic [DATA_W-1:0] lrcQ, lrcBase;

  assign dataIsDle = (inData == cfgDle);

  assign crcBase = ctl.accClr ? '0 : crcQ;
  assign lrcBase = ctl.accClr ? '0 : lrcQ;

  // Reflected CRC, one input bit per step, least significant first
  always_comb begin
    crcStep = crcBase;
    for (int i = 0; i < DATA_W; i++) begin
      if (crcStep[0] ^ inData[i]) crcStep = (crcStep >> 1) ^ CRC_POLY[CRC_W-1:0];
      else                        crcStep = crcStep >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ <= '0;
      lrcQ <= '0;
    end else begin
      crcQ <= ctl.accEn ? crcStep : crcBase;
      lrcQ <= ctl.accEn ? (lrcBase ^ inData) : lrcBase;
    end
  end

  always_comb begin
    case (ctl.sel)
      SEL_DLE:   outData = cfgDle;
      SEL_DATA:  outData = inData;
      SEL_CRCLO: outData = crcQ[DATA_W-1:0];
      SEL_CRCHI: outData = crcQ[HI_LSB +: DATA_W];
      SEL_LRC:   outData = lrcQ;
      default:   outData = cfgSync;
    endcase
  end

endmodule

// File: rtl/bsyncTxControl.sv
module bsyncTxControl
  import bsyncTxPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  outReady,
  input  logic  inValid,
  input  logic  inStart,
  input  logic  inEnd,
  input  logic  inFlagRst,
  input  logic  inFlagLead,
  input  logic  inFlagTransp,
  input  logic  inFlagIncl,
  input  logic  inFlagLast,
  input  logic  cfgUseLrc,
  input  logic  ctsOk,
  input  logic  dataIsDle,
  output dpCtlT ctl,
  output logic  inReady,
  output logic  stValid,
  output logic  stUnderrun,
  output logic  stCtsLost
);

  txStateE st, stNext;
  logic fTransp, fIncl, fLast;
  logic modeTransp, pend, midUnder, inBuf, ctsLost, stuffEnd;
  logic startSlot, startAvail, fin, byteTransp, byteIncl, byteLast, useCrc;

  assign startAvail = inValid && inStart;
  assign startSlot  = outReady && (st == ST_FILL) && startAvail;
  // Flags come straight from the inputs in the slot that opens a buffer
  assign byteTransp = startSlot ? inFlagTransp : fTransp;
  assign byteIncl   = startSlot ? inFlagIncl   : fIncl;
  assign byteLast   = startSlot ? inFlagLast   : fLast;
  assign useCrc     = !cfgUseLrc || fTransp;

  always_comb begin
    ctl     = '{sel: SEL_SYNC, accClr: 1'b0, accEn: 1'b0};
    inReady = 1'b0;
    stValid = 1'b0;
    fin     = 1'b0;
    stNext  = st;
    if (outReady) begin
      case (st)
        ST_FILL, ST_DATA: begin
          if (st == ST_FILL) stValid = pend;
          if (st == ST_FILL && !startAvail) begin
            ctl.sel = modeTransp ? SEL_DLE : SEL_SYNC;
            stNext  = modeTransp ? ST_SYNC2 : ST_FILL;
          end else if (st == ST_FILL && inFlagLead) begin
            ctl.accClr = inFlagRst;
            ctl.sel    = SEL_DLE;
            stNext     = ST_DATA;
          end else if (inValid) begin
            ctl.accClr = startSlot && inFlagRst;
            ctl.sel    = SEL_DATA;
            ctl.accEn  = byteIncl;
            inReady    = 1'b1;
            if (byteTransp && dataIsDle) stNext = ST_STUFF;
            else if (inEnd && byteLast)  stNext = ST_CHK0;
            else if (inEnd) begin
              fin    = 1'b1;
              stNext = ST_FILL;
            end else stNext = ST_DATA;
          end else begin
            ctl.sel = SEL_SYNC;
          end
        end
        ST_STUFF: begin
          ctl.sel = SEL_DLE;
          if (stuffEnd && fLast) stNext = ST_CHK0;
          else if (stuffEnd) begin
            fin    = 1'b1;
            stNext = ST_FILL;
          end else stNext = ST_DATA;
        end
        ST_CHK0: begin
          if (useCrc) begin
            ctl.sel = SEL_CRCLO;
            stNext  = ST_CHK1;
          end else begin
            ctl.sel = SEL_LRC;
            fin     = 1'b1;
            stNext  = ST_FILL;
          end
        end
        ST_CHK1: begin
          ctl.sel = SEL_CRCHI;
          fin     = 1'b1;
          stNext  = ST_FILL;
        end
        default: begin
          ctl.sel = SEL_SYNC;
          stNext  = ST_FILL;
        end
      endcase
    end
  end

  assign stUnderrun = stValid && (midUnder || (!fLast && !startAvail));
  assign stCtsLost  = stValid && ctsLost;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_FILL;
      fTransp    <= 1'b0;
      fIncl      <= 1'b0;
      fLast      <= 1'b0;
      modeTransp <= 1'b0;
      pend       <= 1'b0;
      midUnder   <= 1'b0;
      inBuf      <= 1'b0;
      ctsLost    <= 1'b0;
      stuffEnd   <= 1'b0;
    end else begin
      st <= stNext;
      if (inReady) stuffEnd <= inEnd;
      if (startSlot) begin
        fTransp  <= inFlagTransp;
        fIncl    <= inFlagIncl;
        fLast    <= inFlagLast;
        midUnder <= 1'b0;
        ctsLost  <= !ctsOk;
      end else begin
        if (outReady && st == ST_DATA && !inValid) midUnder <= 1'b1;
        if (inBuf && !ctsOk) ctsLost <= 1'b1;
      end
      if (fin) begin
        inBuf      <= 1'b0;
        pend       <= 1'b1;
        modeTransp <= byteLast ? 1'b0 : byteTransp;
      end else begin
        if (startSlot) inBuf <= 1'b1;
        if (stValid)   pend  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bsyncTxFramer.sv
module bsyncTxFramer
  import bsyncTxPkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          CRC_W    = 16,
  parameter logic [15:0] CRC_POLY = 16'hA001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] cfgSync,
  input  logic [DATA_W-1:0] cfgDle,
  input  logic              cfgUseLrc,
  input  logic              ctsOk,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic              inFlagRst,
  input  logic              inFlagLead,
  input  logic              inFlagTransp,
  input  logic              inFlagIncl,
  input  logic              inFlagLast,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              stValid,
  output logic              stUnderrun,
  output logic              stCtsLost
);

  dpCtlT ctl;
  logic  dataIsDle;

  bsyncTxControl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .outReady    (outReady),
    .inValid     (inValid),
    .inStart     (inStart),
    .inEnd       (inEnd),
    .inFlagRst   (inFlagRst),
    .inFlagLead  (inFlagLead),
    .inFlagTransp(inFlagTransp),
    .inFlagIncl  (inFlagIncl),
    .inFlagLast  (inFlagLast),
    .cfgUseLrc   (cfgUseLrc),
    .ctsOk       (ctsOk),
    .dataIsDle   (dataIsDle),
    .ctl         (ctl),
    .inReady     (inReady),
    .stValid     (stValid),
    .stUnderrun  (stUnderrun),
    .stCtsLost   (stCtsLost)
  );

  bsyncTxDatapath #(
    .DATA_W  (DATA_W),
    .CRC_W   (CRC_W),
    .CRC_POLY(CRC_POLY)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inData   (inData),
    .cfgSync  (cfgSync),
    .cfgDle   (cfgDle),
    .outData  (outData),
    .dataIsDle(dataIsDle)
  );

endmodule

// File: rtl/bsyncTxChecker.sv
module bsyncTxChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] cfgDle,
  input logic [DATA_W-1:0] inData,
  input logic [DATA_W-1:0] outData,
  input logic              inReady,
  input logic              inStart,
  input logic              inFlagTransp,
  input logic              outReady,
  input logic              stValid,
  input logic              stUnderrun,
  input logic              stCtsLost
);

  logic bufTransp, owedStuff, curTransp;

  assign curTransp = inStart ? inFlagTransp : bufTransp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufTransp <= 1'b0;
      owedStuff <= 1'b0;
    end else begin
      if (inReady && inStart) bufTransp <= inFlagTransp;
      if (outReady) owedStuff <= inReady && curTransp && (inData == cfgDle);
    end
  end

  assert_take_in_pull_R13: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (outReady && outData == inData));

  assert_dle_doubled_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && owedStuff) |-> (outData == cfgDle && !inReady));

  assert_underrun_in_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    stUnderrun |-> stValid);

  assert_status_on_pull_R9: assert property (@(posedge clk) disable iff (!rstN)
    stValid |-> outReady);

  assert_cts_in_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    stCtsLost |-> stValid);

endmodule

bind bsyncTxFramer bsyncTxChecker #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cfgDle      (cfgDle),
  .inData      (inData),
  .outData     (outData),
  .inReady     (inReady),
  .inStart     (inStart),
  .inFlagTransp(inFlagTransp),
  .outReady    (outReady),
  .stValid     (stValid),
  .stUnderrun  (stUnderrun),
  .stCtsLost   (stCtsLost)
);

// File: tb/bsyncTxFramer_tb.sv
module bsyncTxFramer_tb_top;

  localparam logic [7:0] SYNC = 8'h32;
  localparam logic [7:0] DLE  = 8'h10;
  localparam int NB = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgUseLrc = 1'b0, ctsOk = 1'b1;
  logic inValid = 1'b0, inStart = 1'b0, inEnd = 1'b0;
  logic inFlagRst = 1'b0, inFlagLead = 1'b0, inFlagTransp = 1'b0, inFlagIncl = 1'b0, inFlagLast = 1'b0;
  logic outReady = 1'b0;
  logic [7:0] inData = 8'h00;
  logic [7:0] outData;
  logic inReady, stValid, stUnderrun, stCtsLost;

  always #5 clk = ~clk;

  bsyncTxFramer dut_i (
    .clk(clk), .rstN(rstN), .cfgSync(SYNC), .cfgDle(DLE), .cfgUseLrc(cfgUseLrc),
    .ctsOk(ctsOk), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inStart(inStart), .inEnd(inEnd), .inFlagRst(inFlagRst), .inFlagLead(inFlagLead),
    .inFlagTransp(inFlagTransp), .inFlagIncl(inFlagIncl), .inFlagLast(inFlagLast),
    .outReady(outReady), .outData(outData), .stValid(stValid),
    .stUnderrun(stUnderrun), .stCtsLost(stCtsLost)
  );

  // Buffer table
  bit fR[NB], fL[NB], fT[NB], fI[NB], fZ[NB];
  int bLen[NB], bBase[NB], bStep[NB], bGap[NB];
  int nDef = 0;

  task automatic addBuf(bit r, bit l, bit t, bit i, bit z, int gap, int len, int base, int step);
    fR[nDef] = r; fL[nDef] = l; fT[nDef] = t; fI[nDef] = i; fZ[nDef] = z;
    bGap[nDef] = gap; bLen[nDef] = len; bBase[nDef] = base; bStep[nDef] = step;
    nDef++;
  endtask

  function automatic logic [7:0] byteOf(int b, int i);
    int v;
    v = bBase[b] + i * bStep[b];
    return v[7:0];
  endfunction

  function automatic logic [15:0] crcUpd(logic [15:0] c, logic [7:0] d);
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ d[k]) c = (c >> 1) ^ 16'hA001;
      else c = c >> 1;
    end
    return c;
  endfunction

  int nChecks = 0, nBad = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model state
  logic [7:0] qVal[$];
  bit qCon[$], qFin[$];
  string qTag[$];
  logic [15:0] mCrc = 16'h0;
  logic [7:0] mLrc = 8'h0;
  bit mMode = 0, owed = 0, pend = 0, pendLast = 0, mLost = 0, mInBuf = 0;
  bit curT = 0, curL = 0, started = 0, lrcPhase = 0;

  task automatic push(logic [7:0] v, bit c, string t);
    qVal.push_back(v); qCon.push_back(c); qFin.push_back(1'b0); qTag.push_back(t);
  endtask

  task automatic build(int b);
    logic [7:0] v;
    curT = fT[b]; curL = fZ[b];
    if (fR[b]) begin mCrc = 16'h0; mLrc = 8'h0; end
    if (fL[b]) push(DLE, 0, "R4");
    for (int i = 0; i < bLen[b]; i++) begin
      v = byteOf(b, i);
      push(v, 1, "R13");
      if (fI[b]) begin mCrc = crcUpd(mCrc, v); mLrc = mLrc ^ v; end
      if (fT[b] && v == DLE) push(DLE, 0, "R5");
    end
    if (fZ[b]) begin
      if (!lrcPhase || fT[b]) begin
        push(mCrc[7:0], 0, fT[b] ? "R8" : "R6 R7");
        push(mCrc[15:8], 0, fT[b] ? "R8" : "R6 R7");
      end else push(mLrc, 0, "R6 R7");
    end
    qFin[qFin.size()-1] = 1'b1;
  endtask

  initial begin
    int bufIdx, pos, gapCnt, cyc;
    bit present, eIn, eSt, eUn, eCts, startSlot, fin, done;
    logic [7:0] eOut;
    string tag;

    addBuf(1,0,0,1,1, 5, 4, 'h41, 1);    // normal, CRC
    addBuf(1,1,1,1,0, 20, 4, 'h0E, 1);   // transparent, lead DLE, DLE inside
    addBuf(0,0,1,1,1, 15, 3, 'h10, 0);   // transparent, all DLE, last
    addBuf(1,0,0,1,0, 12, 2, 'h55, 3);   // normal, not last
    addBuf(0,0,0,0,1, 9, 3, 'h10, 1);    // excluded bytes, DLE unstuffed
    addBuf(1,1,0,1,1, 10, 5, 'h0F, 1);   // LRC phase, lead DLE in normal
    addBuf(1,0,1,1,1, 10, 3, 'h7E, 'h49);// transparent forces CRC
    addBuf(1,0,0,1,0, 30, 6, 'h20, 7);   // CTS drop
    addBuf(1,0,0,1,1, 0, 1, 'h99, 0);    // back to back, single byte

    // Reset state check (R1)
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(outData == SYNC, "R1", "outData in reset", outData, SYNC);
    chk(inReady == 1'b0, "R1", "inReady in reset", inReady, 0);
    chk(stValid == 1'b0, "R1", "stValid in reset", stValid, 0);
    @(negedge clk);
    rstN = 1'b1;

    bufIdx = 0; pos = 0; gapCnt = bGap[0]; done = 0;
    for (cyc = 0; cyc < 20000 && !done; cyc++) begin
      @(negedge clk);
      outReady = lrcPhase ? (cyc % 3 == 0) : 1'b1;
      cfgUseLrc = lrcPhase;
      present = (bufIdx < NB) && (gapCnt == 0);
      inValid = present;
      if (present) begin
        inData = byteOf(bufIdx, pos);
        inStart = (pos == 0);
        inEnd = (pos == bLen[bufIdx] - 1);
        inFlagRst = fR[bufIdx]; inFlagLead = fL[bufIdx]; inFlagTransp = fT[bufIdx];
        inFlagIncl = fI[bufIdx]; inFlagLast = fZ[bufIdx];
      end else begin
        inData = 8'h00; inStart = 0; inEnd = 0;
      end
      ctsOk = !(present && bufIdx == 7 && pos == 2);
      #1;
      eIn = 0; eSt = 0; eUn = 0; eCts = 0; eOut = SYNC; tag = "R1";
      startSlot = 0; fin = 0;
      if (outReady) begin
        if (owed) begin
          owed = 0; eOut = SYNC; tag = "R3";
        end else if (qVal.size() == 0) begin
          if (pend) begin
            eSt = 1;
            eUn = !pendLast && !(present && pos == 0);
            eCts = mLost;
            pend = 0;
          end
          if (present && pos == 0) begin
            build(bufIdx);
            startSlot = 1;
            started = 1;
          end else if (mMode) begin
            eOut = DLE; owed = 1; tag = "R3 R12";
          end else begin
            eOut = SYNC; tag = started ? "R2 R11" : "R1";
          end
        end
        if (qVal.size() != 0 && !(eOut == DLE && owed) && (startSlot || tag == "R1" && qVal.size() != 0)) begin
          eOut = qVal.pop_front(); eIn = qCon.pop_front(); fin = qFin.pop_front(); tag = qTag.pop_front();
        end
        chk(outData == eOut, tag, "outData", outData, eOut);
      end
      chk(inReady == eIn, tag, "inReady", inReady, eIn);
      chk(stValid == eSt, "R9", "stValid", stValid, eSt);
      chk(stUnderrun == eUn, "R9", "stUnderrun", stUnderrun, eUn);
      chk(stCtsLost == eCts, "R10", "stCtsLost", stCtsLost, eCts);
      // clear-to-send tracking over the buffer
      if (startSlot) mLost = !ctsOk;
      else if (mInBuf && !ctsOk) mLost = 1;
      if (fin) begin
        mInBuf = 0; pend = 1; pendLast = curL;
        mMode = curL ? 1'b0 : curT;
      end else if (startSlot) mInBuf = 1;
      // source advance on the design's handshake
      if (inReady && present) begin
        pos++;
        if (pos == bLen[bufIdx]) begin
          bufIdx++; pos = 0;
          if (bufIdx < NB) gapCnt = bGap[bufIdx];
        end
      end else if (!present && gapCnt > 0) gapCnt--;
      if (bufIdx >= 5 && gapCnt <= 2) lrcPhase = 1;
      if (bufIdx >= NB && qVal.size() == 0 && !pend && !owed) done = 1;
    end
    if (!done) begin
      nChecks++; nBad++;
      $display("FAIL watchdog: actual %0d buffers expected %0d", bufIdx, NB);
    end
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule